// File: doc/BRIEF.md
# LIN Master Header Generator

This block builds the header of a LIN frame on one serial transmit line when it runs as bus master. A single-cycle start strobe begins the sequence. The line is first held low for a break whose length comes from two programmable values: an 8-bit prescale value and an 8-bit count value. A prescaler ticks down the count, and the break ends when the count underflows. The line then returns high and a break-done status flag is set. An interrupt can also be raised at that point.

After the break, a built-in 8N1 transmitter sends the sync byte 0x55 and then the identifier byte. When the identifier has fully left the line, the block pulses a header-done output so that the response phase can begin. The control inputs work like register bits: a global enable, a master-select bit and an interrupt enable. The status flag is cleared by writing one to a clear strobe. The interrupt request is dropped by an acknowledge strobe.

Top module: `lin_hdr_top`

## Requirements
- R1: A start strobe begins a header only while lin_en_i=1, master_i=1 and no header is in progress. With either bit at 0 the strobe leaves txd_o high and busy_o low.
- R2: The clock edge that samples the start strobe drives txd_o low. It stays low for exactly (brk_pre_i+1)*(brk_cnt_i+1) clock cycles, using the values present at the start strobe.
- R3: At the end of the break txd_o returns high, and brk_done_o becomes 1 on that same edge.
- R4: When brk_irq_en_i=1 at the break end, irq_o becomes 1 and stays 1 until an irq_ack_i strobe. When brk_irq_en_i=0, irq_o stays 0 and brk_done_o is still set.
- R5: A brk_clr_i strobe clears brk_done_o. irq_o is left unchanged by it.
- R6: Each byte goes out as one start bit at 0, then eight data bits LSB first, then one stop bit at 1. Every bit lasts baud_div_i+1 clock cycles.
- R7: The sync byte 0x55 starts one clock cycle after the break ends. The identifier byte (ident_i, captured at start) starts exactly 10*(baud_div_i+1)+1 cycles after the start of the sync byte.
- R8: One cycle after the identifier stop bit ends, hdr_done_o is 1 for exactly one cycle, and busy_o falls on that same edge.
- R9: A start strobe during a header in progress is ignored. The header finishes unchanged, and no new break follows it.
- R10: Driving lin_en_i to 0 aborts a header. From the next edge txd_o is 1 and busy_o is 0.
- R11: busy_o is 1 from the edge that samples an accepted start strobe until hdr_done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lin_en_i | input | 1 | Global enable; 0 aborts and idles |
| master_i | input | 1 | Master mode select |
| brk_irq_en_i | input | 1 | Break-done interrupt enable |
| start_i | input | 1 | Header start strobe |
| brk_clr_i | input | 1 | Write-one-to-clear of break-done flag |
| irq_ack_i | input | 1 | Interrupt acknowledge strobe |
| brk_pre_i | input | PRE_W | Break prescale value |
| brk_cnt_i | input | CNT_W | Break count value |
| baud_div_i | input | DIV_W | Bit period minus one, in clocks |
| ident_i | input | 8 | Identifier byte |
| txd_o | output | 1 | Serial transmit line |
| busy_o | output | 1 | Header in progress |
| brk_done_o | output | 1 | Break-done status flag |
| irq_o | output | 1 | Break-done interrupt request |
| hdr_done_o | output | 1 | One-cycle pulse at header end |

## Verification
The bench uses the default parameters (8-bit prescale and count, 16-bit divider) and programs a bit period of four clocks. With that period, mid-bit sampling and the exact spacing between the break, the sync byte and the identifier can all be measured to the cycle. The break values cover the shortest break, 0/0 (one cycle), two small mixed pairs, and the longest break, 255/255 (65536 cycles), so the prescaler reload and the count underflow are both exercised at their extremes.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRK,
    ST_SYNC,
    ST_SYNC_WT,
    ST_ID,
    ST_ID_WT
  } hdr_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'h55;
endpackage

// File: rtl/lin_brk_timer.sv
module lin_brk_timer #(
  parameter int PRE_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             uf_o
);
  logic [PRE_W-1:0] pre_q, pre_rl_q;
  logic [CNT_W-1:0] cnt_q;

  assign uf_o = run_i && (pre_q == '0) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q    <= '0;
      pre_rl_q <= '0;
      cnt_q    <= '0;
    end else if (load_i) begin
      pre_q    <= pre_i;
      pre_rl_q <= pre_i;
      cnt_q    <= cnt_i;
    end else if (run_i) begin
      if (pre_q == '0) begin
        pre_q <= pre_rl_q;
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end

  // R2: prescaler never exceeds the captured reload value while running
  p_pre_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (pre_q <= pre_rl_q));
endmodule

// File: rtl/lin_uart_tx.sv
module lin_uart_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic [7:0]       data_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             line_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int NBITS = 10;
  localparam int IDX_W = $clog2(NBITS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NBITS - 1);

  logic             busy_q, line_q;
  logic [8:0]       shft_q;
  logic [IDX_W-1:0] idx_q;
  logic [DIV_W-1:0] tick_q;

  assign line_o = line_q;
  assign busy_o = busy_q;
  assign done_o = busy_q && (tick_q == '0) && (idx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      line_q <= 1'b1;
      shft_q <= '1;
      idx_q  <= '0;
      tick_q <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      line_q <= 1'b1;
      idx_q  <= '0;
      tick_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        line_q <= 1'b0;              // start bit
        shft_q <= {1'b1, data_i};    // data LSB first, then stop
        idx_q  <= '0;
        tick_q <= div_i;
      end
    end else if (tick_q == '0) begin
      if (idx_q == LAST) begin
        busy_q <= 1'b0;
      end else begin
        idx_q  <= idx_q + 1'b1;
        line_q <= shft_q[0];
        shft_q <= {1'b1, shft_q[8:1]};
        tick_q <= div_i;
      end
    end else begin
      tick_q <= tick_q - 1'b1;
    end
  end

  p_idx_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (idx_q <= LAST));
  p_stop_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q == LAST) |-> line_q);
  p_idle_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> line_q);
endmodule

// File: rtl/lin_hdr_ctrl.sv
module lin_hdr_ctrl
  import lin_hdr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lin_en_i,
  input  logic       master_i,
  input  logic       irq_en_i,
  input  logic       start_i,
  input  logic       brk_clr_i,
  input  logic       irq_ack_i,
  input  logic [7:0] ident_i,
  input  logic       uf_i,
  input  logic       u_done_i,
  input  logic       u_busy_i,
  output logic       tmr_load_o,
  output logic       tmr_run_o,
  output logic       u_start_o,
  output logic [7:0] u_data_o,
  output logic       brk_low_o,
  output logic       busy_o,
  output logic       hdr_done_o,
  output logic       brk_flag_o,
  output logic       irq_o
);
  hdr_state_e state_q;
  logic [7:0] id_q;
  logic       go, hdr_done_q, flag_q, irq_q;

  assign go         = start_i && lin_en_i && master_i && (state_q == ST_IDLE);
  assign tmr_load_o = go;
  assign tmr_run_o  = (state_q == ST_BRK);
  assign brk_low_o  = (state_q == ST_BRK);
  assign u_start_o  = (state_q == ST_SYNC) || (state_q == ST_ID);
  assign u_data_o   = (state_q == ST_SYNC) ? SYNC_BYTE : id_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign hdr_done_o = hdr_done_q;
  assign brk_flag_o = flag_q;
  assign irq_o      = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      id_q       <= '0;
      hdr_done_q <= 1'b0;
    end else if (!lin_en_i) begin
      state_q    <= ST_IDLE;
      hdr_done_q <= 1'b0;
    end else begin
      hdr_done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (go) begin
          state_q <= ST_BRK;
          id_q    <= ident_i;
        end
        ST_BRK:     if (uf_i) state_q <= ST_SYNC;
        ST_SYNC:    state_q <= ST_SYNC_WT;
        ST_SYNC_WT: if (u_done_i) state_q <= ST_ID;
        ST_ID:      state_q <= ST_ID_WT;
        ST_ID_WT: if (u_done_i) begin
          state_q    <= ST_IDLE;
          hdr_done_q <= 1'b1;
        end
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (uf_i)           flag_q <= 1'b1;
      else if (brk_clr_i) flag_q <= 1'b0;
      if (uf_i && irq_en_i) irq_q <= 1'b1;
      else if (irq_ack_i)   irq_q <= 1'b0;
    end
  end

  p_flag_on_uf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_i |=> flag_q);
  p_irq_source_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(uf_i && irq_en_i));
  p_id_after_sync_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ID) |-> !u_busy_i);
  p_abort_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lin_en_i |=> (state_q == ST_IDLE));
  p_done_ends_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_done_q |-> (state_q == ST_IDLE));
endmodule

// File: rtl/lin_hdr_top.sv
module lin_hdr_top #(
  parameter int PRE_W = 8,
  parameter int CNT_W = 8,
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lin_en_i,
  input  logic             master_i,
  input  logic             brk_irq_en_i,
  input  logic             start_i,
  input  logic             brk_clr_i,
  input  logic             irq_ack_i,
  input  logic [PRE_W-1:0] brk_pre_i,
  input  logic [CNT_W-1:0] brk_cnt_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic [7:0]       ident_i,
  output logic             txd_o,
  output logic             busy_o,
  output logic             brk_done_o,
  output logic             irq_o,
  output logic             hdr_done_o
);
  logic       tmr_load, tmr_run, uf;
  logic       u_start, u_line, u_busy, u_done, brk_low;
  logic [7:0] u_data;

  lin_brk_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .run_i  (tmr_run),
    .pre_i  (brk_pre_i),
    .cnt_i  (brk_cnt_i),
    .uf_o   (uf)
  );

  lin_uart_tx #(.DIV_W(DIV_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (!lin_en_i),
    .start_i (u_start),
    .data_i  (u_data),
    .div_i   (baud_div_i),
    .line_o  (u_line),
    .busy_o  (u_busy),
    .done_o  (u_done)
  );

  lin_hdr_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lin_en_i   (lin_en_i),
    .master_i   (master_i),
    .irq_en_i   (brk_irq_en_i),
    .start_i    (start_i),
    .brk_clr_i  (brk_clr_i),
    .irq_ack_i  (irq_ack_i),
    .ident_i    (ident_i),
    .uf_i       (uf),
    .u_done_i   (u_done),
    .u_busy_i   (u_busy),
    .tmr_load_o (tmr_load),
    .tmr_run_o  (tmr_run),
    .u_start_o  (u_start),
    .u_data_o   (u_data),
    .brk_low_o  (brk_low),
    .busy_o     (busy_o),
    .hdr_done_o (hdr_done_o),
    .brk_flag_o (brk_done_o),
    .irq_o      (irq_o)
  );

  assign txd_o = brk_low ? 1'b0 : u_line;

  p_line_high_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o);
endmodule

// File: tb/lin_hdr_top_test.sv
module lin_hdr_top_test;
  localparam int D = 4;  // bit period in clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lin_en = 1'b0, master = 1'b0, irq_en = 1'b0;
  logic       start = 1'b0, brk_clr = 1'b0, irq_ack = 1'b0;
  logic [7:0] pre = '0, cnt = '0, ident = '0;
  logic [15:0] baud = 16'(D - 1);
  logic       txd, busy, brk_done, irq, hdr_done;

  int checks = 0, errors = 0;
  int exp_q[$];
  bit finished = 0;

  always #4 clk = ~clk;

  lin_hdr_top uut (
    .clk_i(clk), .rst_ni(rst_n), .lin_en_i(lin_en), .master_i(master),
    .brk_irq_en_i(irq_en), .start_i(start), .brk_clr_i(brk_clr),
    .irq_ack_i(irq_ack), .brk_pre_i(pre), .brk_cnt_i(cnt),
    .baud_div_i(baud), .ident_i(ident), .txd_o(txd), .busy_o(busy),
    .brk_done_o(brk_done), .irq_o(irq), .hdr_done_o(hdr_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic decode(output logic [7:0] v, output logic sb, output logic pb);
    repeat (D / 2) @(negedge clk);
    sb = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (D) @(negedge clk);
      v[i] = txd;
    end
    repeat (D) @(negedge clk);
    pb = txd;
  endtask

  // monitor: scoreboard consumer
  initial begin
    int e, len, gap, n;
    logic [7:0] b;
    logic sb, pb;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        while (txd) @(negedge clk);
        len = 0;
        while (!txd) begin len++; @(negedge clk); end
        chk(len == e, "R2 break length", len, e);
        gap = 0;
        while (txd) begin gap++; @(negedge clk); end
        chk(gap == 1, "R7 break-to-sync gap", gap, 1);
        decode(b, sb, pb);
        e = exp_q.pop_front();
        chk(b == e[7:0], "R7 sync byte", b, e);
        chk(sb == 1'b0 && pb == 1'b1, "R6 sync framing", {sb, pb}, 1);
        n = 0;
        while (txd) begin n++; @(negedge clk); end
        chk(9 * D + D / 2 + n == 10 * D + 1, "R7 sync-to-id spacing",
            9 * D + D / 2 + n, 10 * D + 1);
        decode(b, sb, pb);
        e = exp_q.pop_front();
        chk(b == e[7:0], "R6 id byte", b, e);
        chk(sb == 1'b0 && pb == 1'b1, "R6 id framing", {sb, pb}, 1);
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // driver: pushes expectations, runs one header
  task automatic header(input int p, input int c, input logic [7:0] id,
                        input bit en_irq, input bit restart);
    pre = 8'(p); cnt = 8'(c); ident = id; irq_en = en_irq;
    exp_q.push_back((p + 1) * (c + 1));
    exp_q.push_back(8'h55);
    exp_q.push_back(int'(id));
    pulse_start();
    chk(busy == 1'b1, "R11 busy after start", busy, 1);
    chk(txd == 1'b0, "R2 line low at start", txd, 0);
    if (restart) begin
      while (txd == 1'b0) @(negedge clk);
      repeat (10) @(negedge clk);
      pulse_start();  // R9: must be ignored
    end
    while (!hdr_done) @(negedge clk);
    chk(busy == 1'b0, "R8 busy falls with hdr_done", busy, 0);
    chk(brk_done == 1'b1, "R3 break-done flag", brk_done, 1);
    chk(irq == en_irq, "R4 irq follows enable", irq, en_irq);
    @(negedge clk);
    chk(hdr_done == 1'b0, "R8 hdr_done one cycle", hdr_done, 0);
  endtask

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    chk(txd == 1'b1 && busy == 1'b0 && brk_done == 1'b0 && irq == 1'b0 &&
        hdr_done == 1'b0, "R1 reset state", {txd, busy, brk_done, irq, hdr_done}, 16);
    rst_n = 1'b1;
    lin_en = 1'b1; master = 1'b1;
    @(negedge clk);

    header(1, 2, 8'hA3, 1'b1, 1'b0);
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
    chk(irq == 1'b0, "R4 ack clears irq", irq, 0);
    chk(brk_done == 1'b1, "R4 ack keeps flag", brk_done, 1);
    @(negedge clk) brk_clr = 1'b1;
    @(negedge clk) brk_clr = 1'b0;
    chk(brk_done == 1'b0, "R5 clear strobe", brk_done, 0);

    header(0, 0, 8'h00, 1'b0, 1'b0);
    chk(irq == 1'b0, "R4 irq disabled", irq, 0);
    @(negedge clk) brk_clr = 1'b1; irq_ack = 1'b0;
    @(negedge clk) brk_clr = 1'b0;

    header(3, 1, 8'hFF, 1'b1, 1'b1);
    hi = 0;
    repeat (60) begin @(negedge clk); if (txd && !busy) hi++; end
    chk(hi == 60, "R9 no second header", hi, 60);
    @(negedge clk) irq_ack = 1'b1; brk_clr = 1'b1;
    @(negedge clk) irq_ack = 1'b0; brk_clr = 1'b0;
    chk(irq == 1'b0, "R5 clear leaves irq only to ack", irq, 0);

    // R1: gating by master and enable
    master = 1'b0;
    pulse_start();
    hi = 0;
    repeat (20) begin if (txd && !busy) hi++; @(negedge clk); end
    chk(hi == 20, "R1 master off ignores start", hi, 20);
    master = 1'b1; lin_en = 1'b0;
    pulse_start();
    hi = 0;
    repeat (20) begin if (txd && !busy) hi++; @(negedge clk); end
    chk(hi == 20, "R1 enable off ignores start", hi, 20);
    lin_en = 1'b1;
    @(negedge clk);

    // R10: abort during break, then during sync byte
    pre = 8'd5; cnt = 8'd5;
    pulse_start();
    repeat (3) @(negedge clk);
    lin_en = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1 && busy == 1'b0, "R10 abort in break", {txd, busy}, 2);
    lin_en = 1'b1;
    pre = 8'd0; cnt = 8'd1;
    pulse_start();
    repeat (4) @(negedge clk);
    lin_en = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1 && busy == 1'b0, "R10 abort in sync", {txd, busy}, 2);
    lin_en = 1'b1;
    @(negedge clk) brk_clr = 1'b1; irq_ack = 1'b1;
    @(negedge clk) brk_clr = 1'b0; irq_ack = 1'b0;

    // longest break
    header(255, 255, 8'h3C, 1'b1, 1'b0);
    repeat (5) @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule